// File: doc/BRIEF.md
# Integer-N Synthesizer Divider and Phase Detector

This block is the digital heart of an integer-N frequency synthesizer. It runs on a single system clock. It receives two strobe inputs: one marks each edge of the reference oscillator, the other marks each edge of the voltage-controlled oscillator. A reference divider reduces the reference rate by a programmable ratio. A feedback divider reduces the oscillator rate by P*B+A. It does this with a dual-modulus prescaler of 16/17 or 32/33, a swallow counter A and a main counter B.

The two divided event streams drive a two-flag phase-frequency detector. The detector raises a "source" or "sink" request for the external charge pump. Its polarity can be swapped so that the block suits oscillators with a negative tuning slope. The pump outputs can also be forced high, forced low, or silenced entirely. A lock indicator reports when no correction is pending. A configuration error flag marks divider settings that the swallow scheme cannot honour.

New divider ratios are only adopted at the terminal count of the divider they belong to, or while the block is disabled. As a result, a running division cycle is never cut short. No data streams through the block, so every pin is a plain control or status signal.

Top module: `pll_synth_core`

## Requirements
- R1: While enabled, `ref_evt` pulses for one cycle after every r_div-th `ref_tick`, the pulse appearing the cycle after the terminal tick; an r_div of 0 behaves as 1.
- R2: While enabled, `n_evt` pulses for one cycle after every (P*b_div + a_div)-th `vco_tick`, where P is 16 when `pre_sel` is 0 and 32 when `pre_sel` is 1.
- R3: The feedback divider uses modulus P+1 for the first a_div prescaler cycles and P for the remaining b_div-a_div cycles, so with continuous `vco_tick` the spacing of `n_evt` pulses is exactly P*b_div+a_div cycles.
- R4: With `pump_mode` = 00 and `pump_pol` = 0, `pump_src` is high from the cycle after a `ref_evt` until the cycle after the matching `n_evt`, and `pump_snk` is high likewise for an `n_evt` waiting on a `ref_evt`; with `pump_pol` = 1 the two outputs are swapped.
- R5: When both detector flags would be set at once, both clear in that cycle; `pump_src` and `pump_snk` are never high together.
- R6: `lock_det` is high when `pll_en` is high and neither detector flag is pending.
- R7: Changes to r_div, a_div, b_div and pre_sel take effect at the next terminal count of the affected divider, or immediately while `pll_en` is low.
- R8: While `pll_en` is low, both dividers hold at zero, no events are produced, the detector flags are cleared and `lock_det` is low.
- R9: `pump_mode` 01 forces `pump_src` high and `pump_snk` low; 10 forces `pump_snk` high and `pump_src` low; 11 drives both low; 00 selects the detector.
- R10: `cfg_err` is high whenever a_div >= b_div or b_div < 3, independently of `pll_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_en | input | 1 | Enables the dividers and detector |
| ref_tick | input | 1 | One-cycle strobe per reference edge |
| vco_tick | input | 1 | One-cycle strobe per oscillator edge |
| r_div | input | 15 | Reference divide ratio |
| a_div | input | 7 | Swallow count |
| b_div | input | 11 | Main counter count |
| pre_sel | input | 1 | Prescaler select: 0 for 16/17, 1 for 32/33 |
| pump_pol | input | 1 | Detector polarity swap |
| pump_mode | input | 2 | Pump override: 00 detector, 01 source, 10 sink, 11 off |
| ref_evt | output | 1 | Divided reference event pulse |
| n_evt | output | 1 | Divided oscillator event pulse |
| pump_src | output | 1 | Charge-pump source request |
| pump_snk | output | 1 | Charge-pump sink request |
| lock_det | output | 1 | No pending phase correction |
| cfg_err | output | 1 | Illegal swallow configuration |

## Verification
The bench models the feedback divider as a single counter that wraps at P*B+A, so any slip in the modulus switch shows up as an event landing one or more cycles early or late. Reconfiguring the dividers in mid-count is tested because a design that loaded ratios at once would shorten the running cycle. The measured interval before the change would then not match the old ratio. Coincident reference and feedback events under identical ratios are tested because a detector without a same-cycle clear would leave a flag stuck and drop lock. Both pump polarities are run against a deliberate frequency error, along with the override modes and the limits of the illegal-configuration check, where a swapped comparison or an off-by-one bound would flip `cfg_err`.

// File: rtl/pllsyn_pkg.sv
package pllsyn_pkg;
  typedef enum logic [1:0] {
    PM_DET = 2'b00,
    PM_SRC = 2'b01,
    PM_SNK = 2'b10,
    PM_OFF = 2'b11
  } pump_mode_e;

  localparam int unsigned PRE_LO = 16;
  localparam int unsigned PRE_HI = 32;
  localparam int unsigned PRE_W  = $clog2(PRE_HI + 2);
endpackage

// File: rtl/pllsyn_ref_div.sv
module pllsyn_ref_div #(
  parameter int unsigned W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic [W-1:0] div_in,
  output logic         evt
);
  logic [W-1:0] cnt, act;
  logic         term;

  assign term = (act == '0) || (cnt == act - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      act <= '0;
      evt <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      act <= div_in;
      evt <= 1'b0;
    end else begin
      evt <= 1'b0;
      if (tick) begin
        if (term) begin
          cnt <= '0;
          act <= div_in;
          evt <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pllsyn_swallow_div.sv
module pllsyn_swallow_div
  import pllsyn_pkg::*;
#(
  parameter int unsigned A_W = 7,
  parameter int unsigned B_W = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           tick,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  input  logic           psel_in,
  output logic           evt
);
  logic [PRE_W-1:0] pre_cnt, pre_last;
  logic [A_W-1:0]   a_cnt, a_act;
  logic [B_W-1:0]   b_cnt, b_act;
  logic             psel_act, swallowing, b_term;

  assign swallowing = (a_cnt < a_act);
  always_comb begin
    if (psel_act) pre_last = swallowing ? PRE_W'(PRE_HI) : PRE_W'(PRE_HI - 1);
    else          pre_last = swallowing ? PRE_W'(PRE_LO) : PRE_W'(PRE_LO - 1);
  end
  assign b_term = (b_act <= B_W'(1)) || (b_cnt == b_act - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      a_cnt    <= '0;
      b_cnt    <= '0;
      a_act    <= '0;
      b_act    <= '0;
      psel_act <= 1'b0;
      evt      <= 1'b0;
    end else if (!en) begin
      pre_cnt  <= '0;
      a_cnt    <= '0;
      b_cnt    <= '0;
      a_act    <= a_in;
      b_act    <= b_in;
      psel_act <= psel_in;
      evt      <= 1'b0;
    end else begin
      evt <= 1'b0;
      if (tick) begin
        if (pre_cnt == pre_last) begin
          pre_cnt <= '0;
          if (b_term) begin
            a_cnt    <= '0;
            b_cnt    <= '0;
            a_act    <= a_in;
            b_act    <= b_in;
            psel_act <= psel_in;
            evt      <= 1'b1;
          end else begin
            b_cnt <= b_cnt + 1'b1;
            if (swallowing) a_cnt <= a_cnt + 1'b1;
          end
        end else begin
          pre_cnt <= pre_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pllsyn_pfd.sv
module pllsyn_pfd (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ref_evt,
  input  logic n_evt,
  output logic ref_pend,
  output logic n_pend
);
  logic nxt_r, nxt_n;

  assign nxt_r = ref_pend | ref_evt;
  assign nxt_n = n_pend | n_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_pend <= 1'b0;
      n_pend   <= 1'b0;
    end else if (!en || (nxt_r && nxt_n)) begin
      ref_pend <= 1'b0;
      n_pend   <= 1'b0;
    end else begin
      ref_pend <= nxt_r;
      n_pend   <= nxt_n;
    end
  end
endmodule

// File: rtl/pll_synth_core.sv
module pll_synth_core
  import pllsyn_pkg::*;
#(
  parameter int unsigned R_W   = 15,
  parameter int unsigned A_W   = 7,
  parameter int unsigned B_W   = 11,
  parameter int unsigned B_MIN = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pll_en,
  input  logic           ref_tick,
  input  logic           vco_tick,
  input  logic [R_W-1:0] r_div,
  input  logic [A_W-1:0] a_div,
  input  logic [B_W-1:0] b_div,
  input  logic           pre_sel,
  input  logic           pump_pol,
  input  logic [1:0]     pump_mode,
  output logic           ref_evt,
  output logic           n_evt,
  output logic           pump_src,
  output logic           pump_snk,
  output logic           lock_det,
  output logic           cfg_err
);
  logic ref_pend, n_pend;

  pllsyn_ref_div #(.W(R_W)) u_rdiv (
    .clk(clk), .rst_n(rst_n), .en(pll_en), .tick(ref_tick),
    .div_in(r_div), .evt(ref_evt)
  );

  pllsyn_swallow_div #(.A_W(A_W), .B_W(B_W)) u_ndiv (
    .clk(clk), .rst_n(rst_n), .en(pll_en), .tick(vco_tick),
    .a_in(a_div), .b_in(b_div), .psel_in(pre_sel), .evt(n_evt)
  );

  pllsyn_pfd u_pfd (
    .clk(clk), .rst_n(rst_n), .en(pll_en),
    .ref_evt(ref_evt), .n_evt(n_evt),
    .ref_pend(ref_pend), .n_pend(n_pend)
  );

  always_comb begin
    unique case (pump_mode_e'(pump_mode))
      PM_SRC:  begin pump_src = 1'b1; pump_snk = 1'b0; end
      PM_SNK:  begin pump_src = 1'b0; pump_snk = 1'b1; end
      PM_OFF:  begin pump_src = 1'b0; pump_snk = 1'b0; end
      default: begin
        pump_src = pump_pol ? n_pend   : ref_pend;
        pump_snk = pump_pol ? ref_pend : n_pend;
      end
    endcase
  end

  assign lock_det = pll_en && !ref_pend && !n_pend;
  assign cfg_err  = (B_W'(a_div) >= b_div) || (b_div < B_W'(B_MIN));
endmodule

// File: rtl/pllsyn_chk.sv
module pllsyn_chk #(
  parameter int unsigned R_W = 15,
  parameter int unsigned A_W = 7,
  parameter int unsigned B_W = 11
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pll_en,
  input logic           ref_tick,
  input logic           vco_tick,
  input logic [R_W-1:0] r_div,
  input logic [A_W-1:0] a_div,
  input logic [B_W-1:0] b_div,
  input logic           pre_sel,
  input logic           pump_pol,
  input logic [1:0]     pump_mode,
  input logic           ref_evt,
  input logic           n_evt,
  input logic           pump_src,
  input logic           pump_snk,
  input logic           lock_det,
  input logic           cfg_err
);
  AST_REF_EVT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ref_evt |-> $past(ref_tick)); // R1
  AST_N_EVT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    n_evt |-> $past(vco_tick)); // R2
  AST_PUMP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_src && pump_snk)); // R5
  AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_mode == 2'b00 && lock_det) |-> (!pump_src && !pump_snk)); // R6
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_en |=> (!ref_evt && !n_evt)); // R8
  AST_DISABLED_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_en |-> !lock_det); // R8
  AST_PUMP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pump_mode == 2'b11 |-> (!pump_src && !pump_snk)); // R9
  AST_SHORT_B_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (b_div < 3) |-> cfg_err); // R10
endmodule

bind pll_synth_core pllsyn_chk #(.R_W(R_W), .A_W(A_W), .B_W(B_W)) u_chk (.*);

// File: tb/pll_synth_core_tb.sv
module pll_synth_core_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pll_en = 1'b0;
  logic        ref_tick = 1'b0;
  logic        vco_tick = 1'b0;
  logic [14:0] r_div = 15'd49;
  logic [6:0]  a_div = 7'd1;
  logic [10:0] b_div = 11'd3;
  logic        pre_sel = 1'b0;
  logic        pump_pol = 1'b0;
  logic [1:0]  pump_mode = 2'b00;
  logic        ref_evt, n_evt, pump_src, pump_snk, lock_det, cfg_err;

  int tests = 0, fails = 0, cyc = 0;
  int rnd_ref = 0, rnd_vco = 0;
  int both_hi = 0, last_n = -1, gap_n = 0, n_seen = 0;

  int m_rc, m_ract, m_nc, m_nact;
  bit m_rev, m_nev, m_fr, m_fn;

  pll_synth_core u_dut (
    .clk(clk), .rst_n(rst_n), .pll_en(pll_en), .ref_tick(ref_tick),
    .vco_tick(vco_tick), .r_div(r_div), .a_div(a_div), .b_div(b_div),
    .pre_sel(pre_sel), .pump_pol(pump_pol), .pump_mode(pump_mode),
    .ref_evt(ref_evt), .n_evt(n_evt), .pump_src(pump_src),
    .pump_snk(pump_snk), .lock_det(lock_det), .cfg_err(cfg_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int n_total();
    return (pre_sel ? 32 : 16) * int'(b_div) + int'(a_div);
  endfunction

  // Behavioural reference: whole-ratio counters, no prescaler structure
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_rc = 0; m_ract = 0; m_nc = 0; m_nact = 0;
      m_rev = 0; m_nev = 0; m_fr = 0; m_fn = 0;
    end else if (!pll_en) begin
      m_rc = 0; m_nc = 0; m_ract = int'(r_div); m_nact = n_total();
      m_rev = 0; m_nev = 0; m_fr = 0; m_fn = 0;
    end else begin
      bit nr, nn;
      nr = m_fr | m_rev;
      nn = m_fn | m_nev;
      if (nr && nn) begin m_fr = 0; m_fn = 0; end
      else begin m_fr = nr; m_fn = nn; end
      m_rev = 0;
      if (ref_tick) begin
        if (m_rc == ((m_ract == 0) ? 1 : m_ract) - 1) begin
          m_rc = 0; m_ract = int'(r_div); m_rev = 1;
        end else m_rc++;
      end
      m_nev = 0;
      if (vco_tick) begin
        if (m_nc == m_nact - 1) begin
          m_nc = 0; m_nact = n_total(); m_nev = 1;
        end else m_nc++;
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", req, cyc, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit es, ek;
      case (pump_mode)
        2'b01: begin es = 1; ek = 0; end
        2'b10: begin es = 0; ek = 1; end
        2'b11: begin es = 0; ek = 0; end
        default: begin es = pump_pol ? m_fn : m_fr; ek = pump_pol ? m_fr : m_fn; end
      endcase
      chk("R1 ref_evt", ref_evt, m_rev);
      chk("R2 n_evt", n_evt, m_nev);
      chk("R4 pump_src", pump_src, es);
      chk("R4 pump_snk", pump_snk, ek);
      chk("R6 lock_det", lock_det, pll_en && !m_fr && !m_fn);
      chk("R10 cfg_err", cfg_err, (a_div >= b_div) || (b_div < 3));
      if (pump_src && pump_snk) both_hi++;
      if (n_evt) begin
        if (last_n >= 0) gap_n = cyc - last_n;
        last_n = cyc;
        n_seen++;
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      if (rnd_ref != 0) ref_tick = ($urandom % rnd_ref) == 0;
      if (rnd_vco != 0) vco_tick = ($urandom % rnd_vco) == 0;
    end
  endtask

  task automatic wait_n();
    int s;
    s = n_seen;
    while (n_seen == s) step(1);
  endtask

  task automatic run_done();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    run_done();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    @(negedge clk); #1;
    chk("R8 reset ref_evt", ref_evt, 1'b0);
    chk("R8 reset lock_det", lock_det, 1'b0);
    chk("R8 reset pump_src", pump_src, 1'b0);

    // Matched ratios, continuous ticks: coincident events, lock holds (R5, R6)
    ref_tick = 1; vco_tick = 1; r_div = 49; a_div = 1; b_div = 3; pre_sel = 0;
    step(2); pll_en = 1;
    step(500);
    chk_int("R5 never both pump outputs", both_hi, 0);
    @(negedge clk); #1;
    chk("R6 lock under matched ratios", lock_det, 1'b1);

    // Swallow ratio with 32/33 prescaler (R3)
    pll_en = 0; pre_sel = 1; a_div = 5; b_div = 20; r_div = 600;
    step(3); pll_en = 1;
    wait_n(); wait_n();
    chk_int("R3 feedback spacing P*B+A", gap_n, 32*20 + 5);

    // Frequency error, both polarities (R4)
    pll_en = 0; pre_sel = 0; a_div = 1; b_div = 3; r_div = 40; pump_pol = 0;
    step(3); pll_en = 1; step(600);
    pump_pol = 1; step(600);

    // Mid-count reconfiguration (R7)
    pll_en = 0; r_div = 49; step(3); pll_en = 1;
    wait_n();
    step(5); a_div = 2; b_div = 4;
    wait_n();
    chk_int("R7 running cycle keeps old ratio", gap_n, 49);
    wait_n();
    chk_int("R7 new ratio after terminal count", gap_n, 66);

    // Random tick patterns
    rnd_ref = 3; rnd_vco = 2; r_div = 37; a_div = 7; b_div = 9; pre_sel = 1;
    step(4000);
    r_div = 0; a_div = 0; b_div = 5; pre_sel = 0;
    step(3000);
    pump_pol = 0; a_div = 15; b_div = 16;
    step(3000);

    // Overrides (R9)
    pump_mode = 2'b01; step(50);
    @(negedge clk); #1;
    chk("R9 forced source", pump_src, 1'b1);
    pump_mode = 2'b10; step(50);
    @(negedge clk); #1;
    chk("R9 forced sink", pump_snk, 1'b1);
    pump_mode = 2'b11; step(50);
    @(negedge clk); #1;
    chk("R9 off mode source", pump_src, 1'b0);
    pump_mode = 2'b00; step(200);

    // Disable (R8)
    pll_en = 0; step(2);
    begin
      int evs = 0;
      for (int i = 0; i < 200; i++) begin
        step(1);
        if (ref_evt || n_evt) evs++;
      end
      chk_int("R8 no events while disabled", evs, 0);
    end
    rnd_ref = 0; rnd_vco = 0; ref_tick = 0; vco_tick = 0;

    // Configuration limits (R10)
    a_div = 4; b_div = 4; step(1); @(negedge clk); #1;
    chk("R10 a equal b", cfg_err, 1'b1);
    a_div = 9; b_div = 4; step(1); @(negedge clk); #1;
    chk("R10 a above b", cfg_err, 1'b1);
    a_div = 0; b_div = 2; step(1); @(negedge clk); #1;
    chk("R10 b below minimum", cfg_err, 1'b1);
    a_div = 2; b_div = 3; step(1); @(negedge clk); #1;
    chk("R10 legal minimum", cfg_err, 1'b0);

    step(5);
    run_done();
  end
endmodule